// File: doc/BRIEF.md
# Run-Mode System Clock Configuration Controller

This block turns a single configuration word into a system clock-enable stream. Two behavioural tick inputs stand in for the clocks: `osc_tick_i` marks edges of the raw oscillator and `pll_tick_i` marks edges of the PLL output. Both are sampled on the fabric clock `clk_i`. The configuration word holds five things: a divider field, a use-divider bit, a bypass bit, a PLL power-down bit and a crystal-select field. From these the block picks a source, divides it by a programmable integer, and emits one-cycle pulses on `sys_tick_o`.

Any write that changes the power-down bit or the crystal-select field restarts a relock timer. While that timer runs, or while the PLL is powered down, the block keeps the PLL path away from the output. A PLL-path request is served from the oscillator until the ready flag rises. A new divide ratio or use-divider setting is adopted only at a divider terminal count, so the pulse train never shows a short or partial period.

Top module: `rmclk_ctrl`

## Requirements
- R1: After reset the configuration reads back as divider field 0xF, use-divider 0, bypass 1, power-down 1 and crystal-select 0, with `ready_o` and `pll_sel_o` low. The word layout is: divider at bits 3:0, use-divider at bit 4, bypass at bit 5, power-down at bit 6, bit 7 reads zero, crystal-select from bit 8 up.
- R2: With bypass set and use-divider set, `sys_tick_o` pulses once every (divider field + 1) oscillator ticks.
- R3: With use-divider clear, no division is applied: every selected source tick gives one output pulse.
- R4: While power-down is set, `ready_o` and `pll_sel_o` stay low and PLL ticks have no effect on the output.
- R5: A write that changes the power-down bit or the crystal-select field drops `ready_o` in the cycle after the write.
- R6: `ready_o` rises only after LOCK_CYCLES oscillator ticks have passed since the last relock start. Until then a PLL-path request (bypass clear) is served from the oscillator.
- R7: With bypass clear and `ready_o` high, `pll_sel_o` is high and `sys_tick_o` pulses once every (divider field + 1) PLL ticks.
- R8: The active divide ratio and use-divider setting change only at a divider terminal count. After a divider write, the period in progress completes with the old ratio.
- R9: A write that leaves the power-down bit and crystal-select unchanged does not disturb `ready_o`.
- R10: Each `sys_tick_o` pulse comes exactly one cycle after the selected source tick that completes a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock; all ticks are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | CFG_W | Configuration word to write |
| osc_tick_i | input | 1 | Oscillator edge marker |
| pll_tick_i | input | 1 | PLL output edge marker |
| cfg_o | output | CFG_W | Current configuration word |
| ready_o | output | 1 | PLL locked and powered |
| pll_sel_o | output | 1 | Output currently driven from the PLL path |
| sys_tick_o | output | 1 | Divided system clock-enable pulse |

## Verification
The bench builds the block with LOCK_CYCLES set to 20 and the default 4-bit crystal-select field. With that setting a relock finishes within about forty fabric cycles, so the still-locking window, the lock release and the periods measured after lock all fall within a short run. The oscillator tick is driven every second cycle and the PLL tick every cycle. Because the two sources then give different periods for the same divider, each measured period shows which path is driving the output.

// File: rtl/rmclk_pkg.sv
package rmclk_pkg;
  localparam int unsigned DIV_W    = 4;
  localparam int unsigned DIV_LSB  = 0;
  localparam int unsigned USE_BIT  = 4;
  localparam int unsigned BYP_BIT  = 5;
  localparam int unsigned PD_BIT   = 6;
  localparam int unsigned XTAL_LSB = 8;

  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/rmclk_cfg_reg.sv
module rmclk_cfg_reg
  import rmclk_pkg::*;
#(
  parameter int unsigned XTAL_W = 4,
  localparam int unsigned CFG_W = XTAL_LSB + XTAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  output div_t              div_o,
  output logic              use_div_o,
  output logic              bypass_o,
  output logic              pwrdn_o,
  output logic [XTAL_W-1:0] xtal_o,
  output logic              relock_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic              pd_new;
  logic [XTAL_W-1:0] xtal_new;

  assign pd_new   = wr_data_i[PD_BIT];
  assign xtal_new = wr_data_i[XTAL_LSB +: XTAL_W];

  // PLL-affecting write: power state or crystal change
  assign relock_o = wr_en_i && ((pd_new != pwrdn_o) || (xtal_new != xtal_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o     <= '1;
      use_div_o <= 1'b0;
      bypass_o  <= 1'b1;
      pwrdn_o   <= 1'b1;
      xtal_o    <= '0;
    end else if (wr_en_i) begin
      div_o     <= wr_data_i[DIV_LSB +: DIV_W];
      use_div_o <= wr_data_i[USE_BIT];
      bypass_o  <= wr_data_i[BYP_BIT];
      pwrdn_o   <= pd_new;
      xtal_o    <= xtal_new;
    end
  end

  always_comb begin
    cfg_o                       = '0;
    cfg_o[DIV_LSB +: DIV_W]     = div_o;
    cfg_o[USE_BIT]              = use_div_o;
    cfg_o[BYP_BIT]              = bypass_o;
    cfg_o[PD_BIT]               = pwrdn_o;
    cfg_o[XTAL_LSB +: XTAL_W]   = xtal_o;
  end
endmodule

// File: rtl/rmclk_lock.sv
module rmclk_lock #(
  parameter int unsigned LOCK_CYCLES = 1024,
  localparam int unsigned LOCK_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic pwrdn_i,
  input  logic relock_i,
  output logic ready_o
);
  localparam logic [LOCK_W-1:0] LOAD = LOCK_W'(LOCK_CYCLES);

  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= LOAD;
    else if (relock_i || pwrdn_i)    cnt_q <= LOAD;
    else if (osc_tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = !pwrdn_i && (cnt_q == '0);
endmodule

// File: rtl/rmclk_div.sv
module rmclk_div
  import rmclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  div_t div_i,
  input  logic use_div_i,
  output div_t ratio_o,
  output logic use_o,
  output logic term_o,
  output logic sys_tick_o
);
  div_t cnt_q;

  assign term_o = tick_i && (!use_o || cnt_q == ratio_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      ratio_o    <= '1;
      use_o      <= 1'b0;
      sys_tick_o <= 1'b0;
    end else begin
      sys_tick_o <= term_o;
      if (term_o) begin
        cnt_q   <= '0;
        ratio_o <= div_i;     // settings adopted only at terminal count
        use_o   <= use_div_i;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmclk_ctrl.sv
module rmclk_ctrl
  import rmclk_pkg::*;
#(
  parameter int unsigned XTAL_W      = 4,
  parameter int unsigned LOCK_CYCLES = 1024,
  localparam int unsigned CFG_W = XTAL_LSB + XTAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             osc_tick_i,
  input  logic             pll_tick_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ready_o,
  output logic             pll_sel_o,
  output logic             sys_tick_o
);
  div_t              div_f;
  logic              use_div_f, bypass_f, pwrdn_f, relock;
  logic [XTAL_W-1:0] xtal_f;
  logic              pll_tick_g, sel_tick, div_term, use_act;
  div_t              ratio_act;

  rmclk_cfg_reg #(.XTAL_W(XTAL_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .div_o(div_f), .use_div_o(use_div_f), .bypass_o(bypass_f),
    .pwrdn_o(pwrdn_f), .xtal_o(xtal_f), .relock_o(relock), .cfg_o
  );

  rmclk_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i, .rst_ni, .osc_tick_i, .pwrdn_i(pwrdn_f),
    .relock_i(relock), .ready_o
  );

  // powered-down PLL drives nothing
  assign pll_tick_g = pll_tick_i && !pwrdn_f;
  assign pll_sel_o  = !bypass_f && ready_o;
  assign sel_tick   = pll_sel_o ? pll_tick_g : osc_tick_i;

  rmclk_div u_div (
    .clk_i, .rst_ni, .tick_i(sel_tick), .div_i(div_f),
    .use_div_i(use_div_f), .ratio_o(ratio_act), .use_o(use_act),
    .term_o(div_term), .sys_tick_o
  );
endmodule

// File: rtl/rmclk_ctrl_chk.sv
module rmclk_ctrl_chk
  import rmclk_pkg::*;
#(
  parameter int unsigned XTAL_W = 4,
  localparam int unsigned CFG_W = XTAL_LSB + XTAL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CFG_W-1:0] wr_data_i,
  input logic [CFG_W-1:0] cfg_o,
  input logic             ready_o,
  input logic             pll_sel_o,
  input logic             sys_tick_o,
  input logic             sel_tick,
  input logic             div_term,
  input div_t             ratio_act,
  input logic             use_act
);
  a_r4_pd_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[PD_BIT] |-> (!ready_o && !pll_sel_o));

  a_r5_xtal_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[XTAL_LSB +: XTAL_W] != cfg_o[XTAL_LSB +: XTAL_W]) |=> !ready_o);

  a_r6_no_pll_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !pll_sel_o);

  a_r8_ratio_at_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_term |=> ($stable(ratio_act) && $stable(use_act)));

  a_r9_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !wr_en_i) |=> ready_o);

  a_r10_tick_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_tick_o) |-> $past(sel_tick));
endmodule

bind rmclk_ctrl rmclk_ctrl_chk #(.XTAL_W(XTAL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .cfg_o(cfg_o), .ready_o(ready_o), .pll_sel_o(pll_sel_o),
  .sys_tick_o(sys_tick_o), .sel_tick(sel_tick), .div_term(div_term),
  .ratio_act(ratio_act), .use_act(use_act)
);

// File: tb/sim_rmclk_ctrl.sv
`timescale 1ns/1ps
module sim_rmclk_ctrl;
  localparam int CFG_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic             osc_tick = 1'b0;
  logic             pll_tick = 1'b1;
  logic [CFG_W-1:0] cfg;
  logic             ready, pll_sel, sys_tick;

  int n_checks = 0, n_err = 0;
  int cyc = 0, last = 0, pulses = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rmclk_ctrl #(.XTAL_W(4), .LOCK_CYCLES(20)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .osc_tick_i(osc_tick), .pll_tick_i(pll_tick), .cfg_o(cfg),
    .ready_o(ready), .pll_sel_o(pll_sel), .sys_tick_o(sys_tick)
  );

  // oscillator tick every second cycle
  always @(negedge clk) osc_tick <= ~osc_tick;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measure intervals and pop the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sys_tick) begin
        if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check((cyc - last) == e, t, cyc - last, e);
        end
        last = cyc;
        pulses++;
      end
    end
  end

  task automatic settle(input int n);
    int target;
    target = pulses + n;
    wait (pulses >= target);
  endtask

  task automatic expect_per(input int period, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(period);
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  task automatic write(input logic [CFG_W-1:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #20000;
    n_err++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg == 12'h06F, "R1 cfg", cfg, 12'h06F);
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(pll_sel == 1'b0, "R1 pll_sel", pll_sel, 0);
    settle(2);
    expect_per(2, 3, "R1/R3 undivided osc");

    // R2 bypass divided by 4
    write(12'h073);
    settle(2);
    expect_per(8, 3, "R2 osc div4");

    // R8 ratio change waits for terminal
    write(12'h077);
    settle(2);
    settle(1);
    write(12'h071);
    expect_per(16, 1, "R8 old ratio kept");
    expect_per(4, 2, "R8 new ratio");

    // R4 power-down with PLL path requested
    write(12'h053);
    settle(2);
    expect_per(8, 2, "R4 pll ticks ignored");
    check(ready == 1'b0, "R4 ready", ready, 0);
    check(pll_sel == 1'b0, "R4 pll_sel", pll_sel, 0);

    // R5/R6 power up, crystal 5
    write(12'h513);
    check(ready == 1'b0, "R5 ready after pwrup", ready, 0);
    wait_cyc(30);
    check(ready == 1'b0, "R6 still locking", ready, 0);
    check(pll_sel == 1'b0, "R6 osc while locking", pll_sel, 0);
    wait_cyc(30);
    check(ready == 1'b1, "R6 locked", ready, 1);
    check(pll_sel == 1'b1, "R7 pll_sel", pll_sel, 1);
    settle(2);
    expect_per(4, 3, "R7 pll div4");

    // R9 divider-only write keeps lock
    write(12'h511);
    check(ready == 1'b1, "R9 ready kept", ready, 1);
    settle(2);
    expect_per(2, 3, "R7 pll div2");

    // R3 no division on pll; R10 one pulse per pll tick
    write(12'h501);
    settle(2);
    expect_per(1, 3, "R3/R10 pll undivided");

    // R5 crystal change
    write(12'h711);
    check(ready == 1'b0, "R5 xtal relock", ready, 0);
    check(pll_sel == 1'b0, "R5 pll_sel drop", pll_sel, 0);
    wait_cyc(60);
    check(ready == 1'b1, "R6 relocked", ready, 1);

    // R4 power down
    write(12'h751);
    check(ready == 1'b0, "R4 pd ready", ready, 0);
    check(cfg == 12'h751, "R1 readback", cfg, 12'h751);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule